// File: doc/BRIEF.md
# Byte-Wide Bus Peripheral with Hex Display and Position Readback

This block is a peripheral on a processor's external asynchronous memory bus, and to the processor it looks like a small byte-addressed memory. The bus has an 8-bit bidirectional data path, an 8-bit address and three active-low strobes: chip-enable, output-enable and write-enable. All the logic runs on the processor bus clock. The write strobes, the address and the write data pass through a short synchroniser. A write to the display offset stores one byte. Each nibble of that byte drives one seven-segment digit.

Reads are not clocked. While chip-enable and output-enable are both low and the address falls inside the register window, the block drives a byte onto the data bus. The byte is picked by the low address bits from these sources: the button state, the two bytes of the signed 16-bit X position and the two bytes of the signed 16-bit Y position. A 32-bit processor load reaches the block as four separate byte reads, so every byte has its own offset.

The block has two further bus pins. It never drives the wait line, so it adds no wait states, and it holds its interrupt output low. The position and button values come from a mouse decoder outside this block and enter as plain register inputs.

Top module: `busmap_slave`

## Requirements
- R1: While reset is active and after it is released, the display byte is 0x00, so both digit outputs read 0xC0 and the data bus is left high-impedance.
- R2: A write is taken when write-enable rises while chip-enable is low and the 8-bit address is 0x00. The data byte present at that time is latched once, and the digit outputs show it no later than 4 clock cycles after the rising edge.
- R3: A write pulse with chip-enable high, or with an address other than 0x00, leaves the display byte and both digit outputs unchanged.
- R4: The digit outputs are active low. Bit 0 is segment a, through bit 6 which is segment g, and bit 7 (decimal point) is always 1. The high digit shows bits 7:4 of the display byte and the low digit shows bits 3:0. For example, 0 gives 0xC0, 8 gives 0x80 and F gives 0x8E.
- R5: The read byte depends on the offset in the address: 0x00 gives the button byte, 0x01 gives X[7:0], 0x02 gives X[15:8], 0x03 gives Y[7:0] and 0x04 gives Y[15:8]. Offsets 0x05 to 0x07 read as 0x00.
- R6: The block drives the data bus only while output-enable is low, chip-enable is low and address bits 7:3 are zero. At all other times the bus is high-impedance.
- R7: The wait line is never driven and the interrupt output stays low.
- R8: A read at offset 0x00 returns the button byte and never the display byte. This also holds while a write to offset 0x00 is still passing through the synchroniser, and that pending write still reaches the display.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_data | inout | 8 | Bidirectional data bus |
| bus_addr | input | 8 | Low address bits from the processor |
| ce_n | input | 1 | Chip-enable, active low |
| oe_n | input | 1 | Output-enable, active low |
| we_n | input | 1 | Write-enable, active low |
| wait_n | inout | 1 | Wait line, always released |
| irq | output | 1 | Interrupt output, held low |
| btn_state | input | 8 | Button state byte |
| pos_x | input | 16 | Signed X position |
| pos_y | input | 16 | Signed Y position |
| seg_hi | output | 8 | Active-low segments for the high nibble |
| seg_lo | output | 8 | Active-low segments for the low nibble |

## Verification
Two operations can overlap in the same cycles. One is a write to offset 0x00 that has already been accepted on the bus but is still crossing the synchroniser. The other is an asynchronous read of that same offset. The bench starts this overlap by asserting output-enable on the cycle right after write-enable rises, with chip-enable still low. It then checks two things: the bus must carry the button byte, not the new display byte, and the digits must show the written byte a few cycles later.

// File: rtl/busmap_pkg.sv
package busmap_pkg;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 8;

  typedef struct packed {
    logic              ce_n;
    logic              we_n;
    logic [ADDR_W-1:0] addr;
    logic [BUS_W-1:0]  data;
  } bus_snap_t;

  localparam bus_snap_t SNAP_IDLE = '{ce_n: 1'b1, we_n: 1'b1, addr: '0, data: '0};

  // Active-low segments, bit0 = a .. bit6 = g, bit7 = point (kept off).
  function automatic logic [7:0] nibble_to_seg(input logic [3:0] nib);
    logic [6:0] on;
    case (nib)
      4'h0: on = 7'b0111111;
      4'h1: on = 7'b0000110;
      4'h2: on = 7'b1011011;
      4'h3: on = 7'b1001111;
      4'h4: on = 7'b1100110;
      4'h5: on = 7'b1101101;
      4'h6: on = 7'b1111101;
      4'h7: on = 7'b0000111;
      4'h8: on = 7'b1111111;
      4'h9: on = 7'b1101111;
      4'hA: on = 7'b1110111;
      4'hB: on = 7'b1111100;
      4'hC: on = 7'b0111001;
      4'hD: on = 7'b1011110;
      4'hE: on = 7'b1111001;
      default: on = 7'b1110001;
    endcase
    return {1'b1, ~on};
  endfunction

  // Readback selection by in-window offset.
  function automatic logic [BUS_W-1:0] pick_read_byte(
      input logic [2:0]  ofs,
      input logic [7:0]  btn,
      input logic [15:0] x,
      input logic [15:0] y);
    case (ofs)
      3'd0:    return btn;
      3'd1:    return x[7:0];
      3'd2:    return x[15:8];
      3'd3:    return y[7:0];
      3'd4:    return y[15:8];
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/busmap_strobe_sync.sv
module busmap_strobe_sync
  import busmap_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  data,
  output logic              wr_evt,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BUS_W-1:0]  wr_data
);
  localparam int LAST = STAGES;

  bus_snap_t stg [LAST+1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= SNAP_IDLE;
    else        stg[0] <= '{ce_n: ce_n, we_n: we_n, addr: addr, data: data};
  end

  for (genvar i = 1; i <= LAST; i++) begin : g_chain
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[i] <= SNAP_IDLE;
      else        stg[i] <= stg[i-1];
    end
  end

  // End of write strobe: we_n went high while the older sample had ce_n low.
  assign wr_evt  = stg[LAST-1].we_n && !stg[LAST].we_n && !stg[LAST].ce_n;
  assign wr_addr = stg[LAST].addr;
  assign wr_data = stg[LAST].data;
endmodule

// File: rtl/busmap_read_mux.sv
module busmap_read_mux
  import busmap_pkg::*;
#(
  parameter int WIN_BITS = 3
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic [7:0]        btn,
  input  logic [15:0]       pos_x,
  input  logic [15:0]       pos_y,
  output logic              rd_en,
  output logic [BUS_W-1:0]  rd_data
);
  localparam int HI_W = ADDR_W - WIN_BITS;

  logic in_window;
  logic [2:0] ofs;

  assign in_window = (addr[ADDR_W-1:WIN_BITS] == HI_W'(0));
  assign ofs       = 3'(addr[WIN_BITS-1:0]);
  assign rd_en     = !oe_n && !ce_n && in_window;
  assign rd_data   = pick_read_byte(ofs, btn, pos_x, pos_y);
endmodule

// File: rtl/busmap_seg_digits.sv
module busmap_seg_digits
  import busmap_pkg::*;
#(
  parameter int DIGITS = 2
) (
  input  logic [DIGITS*4-1:0] value,
  output logic [DIGITS*8-1:0] segs
);
  for (genvar d = 0; d < DIGITS; d++) begin : g_dig
    assign segs[d*8 +: 8] = nibble_to_seg(value[d*4 +: 4]);
  end
endmodule

// File: rtl/busmap_slave.sv
module busmap_slave
  import busmap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int WIN_BITS    = 3,
  parameter int DISP_OFS    = 0
) (
  input  logic        clk,
  input  logic        rst_n,
  inout  wire  [7:0]  bus_data,
  input  logic [7:0]  bus_addr,
  input  logic        ce_n,
  input  logic        oe_n,
  input  logic        we_n,
  inout  wire         wait_n,
  output logic        irq,
  input  logic [7:0]  btn_state,
  input  logic [15:0] pos_x,
  input  logic [15:0] pos_y,
  output logic [7:0]  seg_hi,
  output logic [7:0]  seg_lo
);
  localparam int DIGITS = BUS_W / 4;

  logic              wr_evt;
  logic [ADDR_W-1:0] wr_addr;
  logic [BUS_W-1:0]  wr_data;
  logic              disp_hit;
  logic [BUS_W-1:0]  disp_q;
  logic              rd_en;
  logic [BUS_W-1:0]  rd_data;
  logic [DIGITS*8-1:0] segs;

  busmap_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .we_n    (we_n),
    .addr    (bus_addr),
    .data    (bus_data),
    .wr_evt  (wr_evt),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  assign disp_hit = wr_evt && (wr_addr == ADDR_W'(DISP_OFS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        disp_q <= '0;
    else if (disp_hit) disp_q <= wr_data;
  end

  busmap_read_mux #(.WIN_BITS(WIN_BITS)) u_rmux (
    .addr    (bus_addr),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .btn     (btn_state),
    .pos_x   (pos_x),
    .pos_y   (pos_y),
    .rd_en   (rd_en),
    .rd_data (rd_data)
  );

  busmap_seg_digits #(.DIGITS(DIGITS)) u_segs (
    .value (disp_q),
    .segs  (segs)
  );

  assign bus_data = rd_en ? rd_data : 8'bz;
  assign wait_n   = 1'bz;
  assign irq      = 1'b0;
  assign seg_lo   = segs[7:0];
  assign seg_hi   = segs[15:8];
endmodule

// File: rtl/busmap_slave_chk.sv
module busmap_slave_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        ce_n,
  input logic        oe_n,
  input logic [7:0]  bus_addr,
  input logic [15:0] pos_x,
  input logic        rd_en,
  input logic [7:0]  rd_data,
  input logic        wr_evt,
  input logic [7:0]  wr_addr,
  input logic [7:0]  wr_data,
  input logic [7:0]  disp_q,
  input logic [7:0]  seg_lo,
  input logic [7:0]  seg_hi
);
  // R2
  wr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_evt && wr_addr == 8'h00) |=> (disp_q == $past(wr_data)));
  // R2
  wr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_evt |=> !wr_evt);
  // R3
  disp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_evt && wr_addr == 8'h00) |=> $stable(disp_q));
  // R4
  seg_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(disp_q) |-> ($stable(seg_lo) && $stable(seg_hi)));
  // R6
  oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> !rd_en);
  // R6
  ce_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !rd_en);
  // R5
  xlo_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && bus_addr == 8'h01) |-> (rd_data == pos_x[7:0]));
endmodule

bind busmap_slave busmap_slave_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ce_n     (ce_n),
  .oe_n     (oe_n),
  .bus_addr (bus_addr),
  .pos_x    (pos_x),
  .rd_en    (rd_en),
  .rd_data  (rd_data),
  .wr_evt   (wr_evt),
  .wr_addr  (wr_addr),
  .wr_data  (wr_data),
  .disp_q   (disp_q),
  .seg_lo   (seg_lo),
  .seg_hi   (seg_hi)
);

// File: tb/busmap_slave_tb.sv
module busmap_slave_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n;
  tri1  [7:0]  bus_data;
  tri1         wait_n;
  logic [7:0]  bus_addr;
  logic        ce_n, oe_n, we_n;
  logic        irq;
  logic [7:0]  btn_state;
  logic [15:0] pos_x, pos_y;
  logic [7:0]  seg_hi, seg_lo;
  logic        tb_den;
  logic [7:0]  tb_dval;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  logic [7:0] exp_disp;

  assign bus_data = tb_den ? tb_dval : 8'bz;

  busmap_slave u_dut (
    .clk(clk), .rst_n(rst_n), .bus_data(bus_data), .bus_addr(bus_addr),
    .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .wait_n(wait_n), .irq(irq),
    .btn_state(btn_state), .pos_x(pos_x), .pos_y(pos_y),
    .seg_hi(seg_hi), .seg_lo(seg_lo)
  );

  // Segments lit for each hex value, listed as {g,f,e,d,c,b,a}.
  function automatic logic [7:0] seg_of(input logic [3:0] v);
    logic [6:0] lit;
    unique case (v)
      0: lit = 7'h3F;  1: lit = 7'h06;  2: lit = 7'h5B;  3: lit = 7'h4F;
      4: lit = 7'h66;  5: lit = 7'h6D;  6: lit = 7'h7D;  7: lit = 7'h07;
      8: lit = 7'h7F;  9: lit = 7'h6F;  10: lit = 7'h77; 11: lit = 7'h7C;
      12: lit = 7'h39; 13: lit = 7'h5E; 14: lit = 7'h79; 15: lit = 7'h71;
    endcase
    return 8'h80 | {1'b0, ~lit};
  endfunction

  function automatic logic [7:0] read_model(input logic [7:0] a, input bit driven);
    if (!driven || a > 8'h07) return 8'hFF;   // released bus pulled high
    if (a == 8'h00) return btn_state;
    if (a == 8'h01) return pos_x[7:0];
    if (a == 8'h02) return pos_x[15:8];
    if (a == 8'h03) return pos_y[7:0];
    if (a == 8'h04) return pos_y[15:8];
    return 8'h00;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_segs(input string req);
    check(seg_hi == seg_of(exp_disp[7:4]), req, seg_hi, seg_of(exp_disp[7:4]));
    check(seg_lo == seg_of(exp_disp[3:0]), req, seg_lo, seg_of(exp_disp[3:0]));
  endtask

  function automatic logic [7:0] nf_byte();
    return 8'($urandom_range(0, 254));
  endfunction

  task automatic new_sources();
    btn_state = nf_byte();
    pos_x = {nf_byte(), nf_byte()};
    pos_y = {nf_byte(), nf_byte()};
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d, input bit sel);
    @(negedge clk);
    bus_addr = a; tb_dval = d; tb_den = 1'b1; ce_n = !sel;
    repeat (2) @(negedge clk);
    we_n = 1'b0;
    repeat (3) @(negedge clk);
    we_n = 1'b1;
    repeat (4) @(negedge clk);
    ce_n = 1'b1; tb_den = 1'b0;
    if (sel && a == 8'h00) exp_disp = d;
    @(negedge clk);
  endtask

  task automatic bus_read(input logic [7:0] a, input bit oe_on, input string req);
    logic [7:0] e;
    @(negedge clk);
    bus_addr = a; ce_n = 1'b0; oe_n = !oe_on;
    @(negedge clk);
    e = read_model(a, oe_on);
    check(bus_data == e, req, bus_data, e);
    oe_n = 1'b1; ce_n = 1'b1;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog all-requirements actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
    bus_addr = '0; tb_den = 1'b0; tb_dval = '0;
    btn_state = 8'h21; pos_x = 16'h1234; pos_y = 16'hFEDC;
    exp_disp = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(seg_hi == 8'hC0 && seg_lo == 8'hC0, "R1 reset digits", {seg_hi, seg_lo}, 16'hC0C0);
    check(bus_data == 8'hFF, "R1 reset bus released", bus_data, 8'hFF);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_segs("R1 after reset");
    // R7
    check(wait_n === 1'b1 && irq == 1'b0, "R7 wait/irq idle", {wait_n, irq}, 2'b10);

    // R2 / R4 directed values
    bus_write(8'h00, 8'hF8, 1'b1); check_segs("R4 F8 digits");
    check(seg_hi == 8'h8E && seg_lo == 8'h80, "R4 F/8 codes", {seg_hi, seg_lo}, 16'h8E80);
    bus_write(8'h00, 8'h3C, 1'b1); check_segs("R2 write 3C");
    // R3 ignored writes
    bus_write(8'h00, 8'h77, 1'b0); check_segs("R3 ce high");
    bus_write(8'h01, 8'h77, 1'b1); check_segs("R3 offset 1");
    bus_write(8'h80, 8'h77, 1'b1); check_segs("R3 offset 80");
    // R5 all offsets
    for (int a = 0; a < 8; a++) bus_read(8'(a), 1'b1, "R5 offset map");
    // R6 outside window and strobe gating
    bus_read(8'h08, 1'b1, "R6 above window");
    bus_read(8'hFF, 1'b1, "R6 top address");
    bus_read(8'h02, 1'b0, "R6 oe high");
    @(negedge clk); bus_addr = 8'h01; ce_n = 1'b1; oe_n = 1'b0;
    @(negedge clk); check(bus_data == 8'hFF, "R6 ce high", bus_data, 8'hFF);
    oe_n = 1'b1;

    // R8: read offset 0 right after a write to offset 0 ends
    @(negedge clk);
    bus_addr = 8'h00; tb_dval = 8'hA5; tb_den = 1'b1; ce_n = 1'b0;
    repeat (2) @(negedge clk); we_n = 1'b0;
    repeat (3) @(negedge clk); we_n = 1'b1;
    @(negedge clk); tb_den = 1'b0; oe_n = 1'b0;
    #0.5;
    check(bus_data == btn_state, "R8 read during pending write", bus_data, btn_state);
    exp_disp = 8'hA5;
    repeat (4) @(negedge clk);
    check(bus_data == btn_state, "R8 read after write", bus_data, btn_state);
    oe_n = 1'b1; ce_n = 1'b1;
    check_segs("R8 pending write landed");

    // Constrained random mix
    for (int n = 0; n < 150; n++) begin
      int op;
      new_sources();
      op = $urandom_range(0, 3);
      case (op)
        0: begin bus_write(8'h00, 8'($urandom_range(0, 255)), 1'b1); check_segs("R2 random write"); end
        1: begin
             if ($urandom_range(0, 1) == 1) bus_write(8'h00, 8'($urandom), 1'b0);
             else bus_write(8'($urandom_range(1, 255)), 8'($urandom), 1'b1);
             check_segs("R3 random ignored write");
           end
        2: bus_read(8'($urandom_range(0, 15)), 1'b1, "R5 random read");
        default: bus_read(8'($urandom_range(0, 4)), 1'b0, "R6 random oe high");
      endcase
    end
    check(wait_n === 1'b1 && irq == 1'b0, "R7 wait/irq idle at end", {wait_n, irq}, 2'b10);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule